// File: doc/BRIEF.md
# Replicated One-Write Two-Read Memory

This block is a single-clock memory with one write port and two read ports that can all be used in the same cycle. Instead of one array with two read/write ports, it holds two complete, identical copies of the storage. Each copy is a simple dual-port bank with one write side and one read side. A write goes to both copies at the same address in the same cycle. Read port A reads only its own copy, and read port B reads only the other copy.

The usual pattern is to write a word and then read it back through both ports at once, each port at its own address. Both copies are the full depth, so the two read ports see the whole address space. The cost is twice the storage, and in return each bank is a simple dual-port structure that closes timing at high clock rates. Read data is registered, and each read port holds its output while its enable is low. Reset clears only the two output registers and leaves the stored words as they are.

Top module: `rep1w2r_mem`

## Requirements
- R1: A read issued with its enable high at clock edge N shows its data on that port's output after edge N and holds it until edge N+1 at least. Everything runs on the single clock `clk`.
- R2: A word written with `wr_en` high at edge N can be read from either port from edge N+1 onward, until it is overwritten.
- R3: The two read ports are independent. In one cycle, port A and port B can each read a different address and each returns the word stored at its own address.
- R4: Each port reaches all 2**ADDR_W words, from address 0 to 2**ADDR_W-1. Word width (`DATA_W`, default 8) and address width (`ADDR_W`, default 6) are parameters.
- R5: When a read and the write hit the same address in the same cycle, the read returns the contents from before that write. This holds for both ports in the same way.
- R6: While a port's read enable is low, its output keeps its previous value, even when the word it last read is overwritten.
- R7: Asserting `rst_n` low forces both read outputs to zero at once, without waiting for a clock edge. Stored words are kept across reset.
- R8: When both ports read the same address in the same cycle, they return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for writes, reads and outputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block; clears read outputs |
| wr_en | input | 1 | Write strobe; the write goes to both copies |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rda_en | input | 1 | Read enable, port A |
| rda_addr | input | ADDR_W | Read address, port A |
| rda_data | output | DATA_W | Registered read data, port A |
| rdb_en | input | 1 | Read enable, port B |
| rdb_addr | input | ADDR_W | Read address, port B |
| rdb_data | output | DATA_W | Registered read data, port B |

## Verification
The bench builds the memory with `DATA_W` = 12 and `ADDR_W` = 5. With 32 words, a complete write sweep followed by opposed read sweeps (A rising, B falling) takes only a few dozen cycles. This exercises both end addresses, and the 12-bit words make each address's pattern distinct from the others. The same small depth makes random traffic produce read/write collisions and equal-address reads on both ports often, so the old-data and agreement rules are checked many times. A mid-run reset then confirms that the stored words survive while the outputs clear.

// File: rtl/rep1w2r_pkg.sv
package rep1w2r_pkg;

  // Number of storage copies, one per read port.
  localparam int unsigned NUM_COPIES = 2;

  // Index of each read port / copy.
  typedef enum logic [0:0] {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } rd_port_e;

endpackage

// File: rtl/rep1w2r_wr_fanout.sv
// Broadcasts the single write command to every storage copy.
module rep1w2r_wr_fanout #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned COPIES = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [COPIES-1:0] cp_wr_en,
  output logic [ADDR_W-1:0] cp_wr_addr [COPIES],
  output logic [DATA_W-1:0] cp_wr_data [COPIES]
);

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    always_comb begin
      cp_wr_en[g]   = wr_en;
      cp_wr_addr[g] = wr_addr;
      cp_wr_data[g] = wr_data;
    end
  end

endmodule

// File: rtl/rep1w2r_bank.sv
// One storage copy: one write side, one read side, registered output.
module rep1w2r_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rd_q;

  // Storage write: no reset, contents survive reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  // Next-state: the array is sampled before this edge's write lands,
  // so a colliding read sees the old word.
  always_comb begin
    rd_nxt = cells[rd_addr];
  end

  // Output register with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_nxt;
    end
  end

  assign rd_data = rd_q;

  // R6: output holds while the read enable is low.
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R7: the output is zero in the first cycle after reset release.
  a_r7_out_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0));

endmodule

// File: rtl/rep1w2r_mem.sv
// One write port, two read ports, built from two full-depth copies.
module rep1w2r_mem
  import rep1w2r_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rda_en,
  input  logic [ADDR_W-1:0] rda_addr,
  output logic [DATA_W-1:0] rda_data,
  input  logic              rdb_en,
  input  logic [ADDR_W-1:0] rdb_addr,
  output logic [DATA_W-1:0] rdb_data
);

  localparam int unsigned COPIES = NUM_COPIES;

  logic [COPIES-1:0] cp_wr_en;
  logic [ADDR_W-1:0] cp_wr_addr [COPIES];
  logic [DATA_W-1:0] cp_wr_data [COPIES];

  logic [COPIES-1:0] rd_en_v;
  logic [ADDR_W-1:0] rd_addr_v [COPIES];
  logic [DATA_W-1:0] rd_data_v [COPIES];

  // Collect the read ports into per-copy vectors.
  always_comb begin
    rd_en_v[PORT_A]   = rda_en;
    rd_en_v[PORT_B]   = rdb_en;
    rd_addr_v[PORT_A] = rda_addr;
    rd_addr_v[PORT_B] = rdb_addr;
  end

  assign rda_data = rd_data_v[PORT_A];
  assign rdb_data = rd_data_v[PORT_B];

  rep1w2r_wr_fanout #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .COPIES (COPIES)
  ) u_fanout (
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cp_wr_en   (cp_wr_en),
    .cp_wr_addr (cp_wr_addr),
    .cp_wr_data (cp_wr_data)
  );

  // One full-depth copy per read port; each port reads only its own copy.
  for (genvar g = 0; g < COPIES; g++) begin : g_bank
    rep1w2r_bank #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cp_wr_en[g]),
      .wr_addr (cp_wr_addr[g]),
      .wr_data (cp_wr_data[g]),
      .rd_en   (rd_en_v[g]),
      .rd_addr (rd_addr_v[g]),
      .rd_data (rd_data_v[g])
    );
  end

  // R8: both ports at the same address return the same word.
  a_r8_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_en && rdb_en && (rda_addr == rdb_addr)) |=> (rda_data == rdb_data));

  // R2: a write is visible on port A one cycle later.
  a_r2_write_seen_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rda_en && (rda_addr == $past(wr_addr)))
      |=> (rda_data == $past(wr_data, 2)));

  // R2: a write is visible on port B one cycle later.
  a_r2_write_seen_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rdb_en && (rdb_addr == $past(wr_addr)))
      |=> (rdb_data == $past(wr_data, 2)));

endmodule

// File: tb/sim_rep1w2r_mem.sv
module sim_rep1w2r_mem;

  localparam int unsigned DW    = 12;
  localparam int unsigned AW    = 5;
  localparam int unsigned DEPTH = 1 << AW;

  typedef struct {
    bit          port_b;
    logic [DW-1:0] expv;
    string       req;
  } sb_item_t;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rda_en;
  logic [AW-1:0] rda_addr;
  logic [DW-1:0] rda_data;
  logic          rdb_en;
  logic [AW-1:0] rdb_addr;
  logic [DW-1:0] rdb_data;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] last_a;
  logic [DW-1:0] last_b;
  sb_item_t      sb [$];
  int            n_checks;
  int            n_fail;
  bit            done;

  rep1w2r_mem #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rda_en (rda_en), .rda_addr (rda_addr), .rda_data (rda_data),
    .rdb_en (rdb_en), .rdb_addr (rdb_addr), .rdb_data (rdb_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] expv);
    n_checks++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, expv);
    end
  endtask

  // Monitor: after each edge, compare everything the driver queued.
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      if (it.port_b) check(it.req, "port B", rdb_data, it.expv);
      else           check(it.req, "port A", rda_data, it.expv);
    end
  end

  // Driver: one cycle of stimulus, expected values from the pre-write array.
  task automatic step(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input bit ea, input logic [AW-1:0] aa,
                      input bit eb, input logic [AW-1:0] ab, input string req);
    sb_item_t ia;
    sb_item_t ib;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rda_en = ea; rda_addr = aa;
    rdb_en = eb; rdb_addr = ab;
    if (ea) last_a = ref_mem[aa];
    if (eb) last_b = ref_mem[ab];
    ia.port_b = 1'b0; ia.expv = last_a; ia.req = req;
    ib.port_b = 1'b1; ib.expv = last_b; ib.req = req;
    sb.push_back(ia);
    sb.push_back(ib);
    if (we) ref_mem[wa] = wd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    last_a = '0; last_b = '0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rda_en = 1'b0; rda_addr = '0; rdb_en = 1'b0; rdb_addr = '0;
    #1;
    check("R7", "reset port A", rda_data, '0);
    check("R7", "reset port B", rdb_data, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2/R6: fill every word with reads idle, outputs stay at zero.
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, AW'(i), DW'(12'h5A0 ^ (i * 37)), 1'b0, '0, 1'b0, '0, "R6");

    // R3/R4: opposed sweeps across the full depth.
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, '0, '0, 1'b1, AW'(i), 1'b1, AW'(DEPTH - 1 - i), "R4");

    // R2/R1: write then read back on both ports the next cycle.
    step(1'b1, AW'(7), 12'hC3E, 1'b0, '0, 1'b0, '0, "R2");
    step(1'b0, '0, '0, 1'b1, AW'(7), 1'b1, AW'(7), "R2");
    step(1'b0, '0, '0, 1'b1, AW'(0), 1'b1, AW'(DEPTH - 1), "R1");

    // R5: collision on both ports returns the old word, then the new one.
    step(1'b1, AW'(9), 12'h0F1, 1'b1, AW'(9), 1'b1, AW'(9), "R5");
    step(1'b1, AW'(9), 12'h777, 1'b1, AW'(9), 1'b1, AW'(9), "R5");
    step(1'b0, '0, '0, 1'b1, AW'(9), 1'b1, AW'(9), "R5");
    // R5: collision on one port only, other port elsewhere.
    step(1'b1, AW'(3), 12'hABC, 1'b1, AW'(3), 1'b1, AW'(4), "R5");
    step(1'b1, AW'(4), 12'h123, 1'b1, AW'(3), 1'b1, AW'(4), "R5");

    // R8: both ports on the same address.
    step(1'b0, '0, '0, 1'b1, AW'(DEPTH - 1), 1'b1, AW'(DEPTH - 1), "R8");

    // R6: enables low while the held word is overwritten.
    step(1'b0, '0, '0, 1'b1, AW'(12), 1'b1, AW'(13), "R6");
    step(1'b1, AW'(12), 12'hE01, 1'b0, '0, 1'b0, '0, "R6");
    step(1'b1, AW'(13), 12'hE02, 1'b0, AW'(13), 1'b0, AW'(12), "R6");
    step(1'b0, '0, '0, 1'b1, AW'(12), 1'b0, '0, "R6");

    // R7: reset mid-run clears outputs at once, storage persists.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", "mid-run reset port A", rda_data, '0);
    check("R7", "mid-run reset port B", rdb_data, '0);
    last_a = '0; last_b = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, '0, '0, 1'b1, AW'(12), 1'b1, AW'(7), "R7");

    // R3/R5/R8: random traffic over the small address space.
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), AW'($urandom_range(0, DEPTH - 1)), DW'($urandom),
           1'($urandom_range(0, 3) != 0), AW'($urandom_range(0, DEPTH - 1)),
           1'($urandom_range(0, 3) != 0), AW'($urandom_range(0, DEPTH - 1)), "R3");

    @(negedge clk);
    wr_en = 1'b0; rda_en = 1'b0; rdb_en = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule